// File: doc/BRIEF.md
# Momentum Lookup Address Former

This block turns the azimuth coordinates of a muon track's segments into the address of a signed transverse-momentum lookup table and reads that table. It takes two azimuth differences: first segment minus second, and second minus third. Each difference is clipped to the few bits that carry information. The second difference is kept at a coarser scale, because it only has to separate low-momentum multiple-scattering effects. The two clipped differences are packed with the track's pseudo-rapidity and track type into one address.

Tracks built from two segments and tracks built from three segments share one address space. For a two-segment track the second-difference field is forced to zero, and the track-type field tells the two cases apart. The table is modelled as an internal synchronous RAM that is filled through a plain write port. A read presented with a valid strobe returns the signed momentum word one clock later, together with the address that produced it. The sign of the word gives the muon charge.

Top module: `mom_addr_former`

## Requirements
- R1: While `rst_n` is low and after its release, `pt_vld`, `pt_val` and `pt_addr` are all zero until the first accepted track.
- R2: Address bits [7:0] hold `phi_a - phi_b` as signed two's complement, clamped to the range -128..127.
- R3: For a three-segment track (`three_st`=1), address bits [12:8] hold `(phi_b - phi_c)` shifted right arithmetically by 2 (floor division by 4), clamped to -16..15.
- R4: For a two-segment track (`three_st`=0), address bits [12:8] are zero whatever `phi_c` holds.
- R5: Address bits [16:13] carry `eta` and bits [20:17] carry `trk_type`, unchanged.
- R6: `pt_vld` is high in exactly the cycle after each cycle in which `trk_vld` is high, and `pt_addr` shows the address formed from that cycle's inputs.
- R7: `pt_val` returns, bit for bit and with its sign, the word last written to the RAM entry selected by the low `RAM_AW` bits (default 10) of the address.
- R8: When a write and a read hit the same entry in the same cycle, the read returns the value held before that write.
- R9: In a cycle with `trk_vld` low, `pt_val` and `pt_addr` keep their previous values, even if the other inputs change or writes occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trk_vld | input | 1 | Track inputs valid; starts a lookup |
| phi_a | input | 12 | Azimuth of first segment (unsigned) |
| phi_b | input | 12 | Azimuth of second segment (unsigned) |
| phi_c | input | 12 | Azimuth of third segment (unsigned) |
| three_st | input | 1 | 1 = third segment present |
| eta | input | 4 | Track pseudo-rapidity code |
| trk_type | input | 4 | Track type code |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 21 | Table write address |
| wr_data | input | 8 | Signed momentum word to write |
| pt_vld | output | 1 | Lookup result valid |
| pt_val | output | 8 | Signed momentum word read |
| pt_addr | output | 21 | Address used for the result |

## Verification
A vector table runs both differences through small positive and negative values. It also covers values exactly at the clip limits and values one step past them, which separates correct clamping from wrap-around and from off-by-one limits. Odd negative second differences show whether the coarse shift floors or truncates toward zero. Two-segment vectors carry a large `phi_c`, so a missing zero-force would show in the field. Directed tests cover the reset state, a write and a read to the same entry in one cycle, and idle cycles with changing inputs and writes, where the outputs must hold.

// File: rtl/maf_pkg.sv
// Package: shared defaults and types for the momentum lookup address former.
// Assumes: widths used by the modules are passed as parameters; these are defaults.
package maf_pkg;
    localparam int PHI_W_DEF   = 12;
    localparam int D1_W_DEF    = 8;
    localparam int D2_W_DEF    = 5;
    localparam int ETA_W_DEF   = 4;
    localparam int TYPE_W_DEF  = 4;
    localparam int PT_W_DEF    = 8;
    localparam int RAM_AW_DEF  = 10;

    // Number of segments that make up the track
    typedef enum logic {
        SEG_PAIR   = 1'b0,
        SEG_TRIPLE = 1'b1
    } seg_count_e;
endpackage

// File: rtl/maf_sat_diff.sv
// Module: unsigned subtraction, arithmetic right shift, signed saturation.
// Does: field = clamp((a - b) >>> SHIFT) into an OUT_W-bit two's complement range.
// Assumes: IN_W + 1 > OUT_W so the full difference is wider than the field.
module maf_sat_diff #(
    parameter int IN_W  = 12,
    parameter int OUT_W = 8,
    parameter int SHIFT = 0
) (
    input  logic [IN_W-1:0]  minuend,
    input  logic [IN_W-1:0]  subtrahend,
    output logic [OUT_W-1:0] field
);
    localparam int DW    = IN_W + 1;
    localparam int MAX_I = (2 ** (OUT_W - 1)) - 1;
    localparam logic signed [DW-1:0] MAX_V = DW'(MAX_I);
    localparam logic signed [DW-1:0] MIN_V = DW'(-MAX_I - 1);

    logic signed [DW-1:0] diff;
    logic signed [DW-1:0] scaled;

    // Full-precision signed difference and coarse scaling
    always_comb begin
        diff   = $signed({1'b0, minuend}) - $signed({1'b0, subtrahend});
        scaled = diff >>> SHIFT;
    end

    // Clamp to the field range, keeping the sign
    always_comb begin
        if (scaled > MAX_V)
            field = MAX_V[OUT_W-1:0];
        else if (scaled < MIN_V)
            field = MIN_V[OUT_W-1:0];
        else
            field = scaled[OUT_W-1:0];
    end
endmodule

// File: rtl/maf_addr_pack.sv
// Module: packs the lookup address from the clipped fields.
// Layout (LSB first): first difference, second difference, eta, track type.
// Assumes: the second-difference field is meaningless for two-segment tracks.
module maf_addr_pack
    import maf_pkg::*;
#(
    parameter int D1_W   = 8,
    parameter int D2_W   = 5,
    parameter int ETA_W  = 4,
    parameter int TYPE_W = 4,
    parameter int ADDR_W = D1_W + D2_W + ETA_W + TYPE_W
) (
    input  logic [D1_W-1:0]   d1_field,
    input  logic [D2_W-1:0]   d2_field,
    input  logic [ETA_W-1:0]  eta,
    input  logic [TYPE_W-1:0] trk_type,
    input  seg_count_e        seg_cnt,
    output logic [ADDR_W-1:0] addr
);
    logic [D2_W-1:0] d2_used;

    // Two-segment tracks carry a zero second difference
    always_comb begin
        d2_used = (seg_cnt == SEG_TRIPLE) ? d2_field : '0;
        addr    = {trk_type, eta, d2_used, d1_field};
    end
endmodule

// File: rtl/maf_pt_ram.sv
// Module: single-clock table RAM, one write and one read port.
// Does: synchronous write; synchronous read on rd_en, read-before-write.
// Assumes: contents are not reset; only the read register is.
module maf_pt_ram #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 2 ** AW;

    logic [DW-1:0] mem [DEPTH];

    // Table write
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_idx] <= wr_data;
    end

    // Table read; holds when no read is requested
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= mem[rd_idx];
    end
endmodule

// File: rtl/mom_addr_former.sv
// Module: momentum lookup address former (top).
// Does: forms the table address from segment azimuths, eta and track type,
//       reads the signed momentum word with one clock of latency.
// Assumes: RAM_AW <= ADDR_W; the model RAM decodes the low RAM_AW address bits.
module mom_addr_former
    import maf_pkg::*;
#(
    parameter int PHI_W    = PHI_W_DEF,
    parameter int D1_W     = D1_W_DEF,
    parameter int D2_W     = D2_W_DEF,
    parameter int D1_SHIFT = 0,
    parameter int D2_SHIFT = 2,
    parameter int ETA_W    = ETA_W_DEF,
    parameter int TYPE_W   = TYPE_W_DEF,
    parameter int PT_W     = PT_W_DEF,
    parameter int RAM_AW   = RAM_AW_DEF,
    localparam int ADDR_W  = D1_W + D2_W + ETA_W + TYPE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trk_vld,
    input  logic [PHI_W-1:0]  phi_a,
    input  logic [PHI_W-1:0]  phi_b,
    input  logic [PHI_W-1:0]  phi_c,
    input  logic              three_st,
    input  logic [ETA_W-1:0]  eta,
    input  logic [TYPE_W-1:0] trk_type,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [PT_W-1:0]   wr_data,
    output logic              pt_vld,
    output logic [PT_W-1:0]   pt_val,
    output logic [ADDR_W-1:0] pt_addr
);
    logic [D1_W-1:0]   d1_field;
    logic [D2_W-1:0]   d2_field;
    logic [ADDR_W-1:0] rd_addr;
    seg_count_e        seg_cnt;

    // Segment count from the third-segment flag
    always_comb seg_cnt = seg_count_e'(three_st);

    maf_sat_diff #(.IN_W(PHI_W), .OUT_W(D1_W), .SHIFT(D1_SHIFT)) diff1_i (
        .minuend   (phi_a),
        .subtrahend(phi_b),
        .field     (d1_field)
    );

    maf_sat_diff #(.IN_W(PHI_W), .OUT_W(D2_W), .SHIFT(D2_SHIFT)) diff2_i (
        .minuend   (phi_b),
        .subtrahend(phi_c),
        .field     (d2_field)
    );

    maf_addr_pack #(
        .D1_W(D1_W), .D2_W(D2_W), .ETA_W(ETA_W), .TYPE_W(TYPE_W), .ADDR_W(ADDR_W)
    ) pack_i (
        .d1_field(d1_field),
        .d2_field(d2_field),
        .eta     (eta),
        .trk_type(trk_type),
        .seg_cnt (seg_cnt),
        .addr    (rd_addr)
    );

    maf_pt_ram #(.AW(RAM_AW), .DW(PT_W)) ram_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_addr[RAM_AW-1:0]),
        .wr_data(wr_data),
        .rd_en  (trk_vld),
        .rd_idx (rd_addr[RAM_AW-1:0]),
        .rd_data(pt_val)
    );

    // Valid and address travel alongside the table read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pt_vld  <= 1'b0;
            pt_addr <= '0;
        end else begin
            pt_vld <= trk_vld;
            if (trk_vld)
                pt_addr <= rd_addr;
        end
    end
endmodule

// File: rtl/maf_chk.sv
// Module: property checker for mom_addr_former, attached by bind.
// Assumes: field layout as packed by maf_addr_pack.
module maf_chk #(
    parameter int ETA_W  = 4,
    parameter int TYPE_W = 4,
    parameter int D1_W   = 8,
    parameter int D2_W   = 5,
    parameter int PT_W   = 8,
    parameter int ADDR_W = 21
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trk_vld,
    input logic              three_st,
    input logic [ETA_W-1:0]  eta,
    input logic [TYPE_W-1:0] trk_type,
    input logic              pt_vld,
    input logic [PT_W-1:0]   pt_val,
    input logic [ADDR_W-1:0] pt_addr
);
    localparam int D2_LO   = D1_W;
    localparam int ETA_LO  = D1_W + D2_W;
    localparam int TYPE_LO = ETA_LO + ETA_W;

    // R6
    vld_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trk_vld |=> pt_vld);

    // R6
    vld_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trk_vld |=> !pt_vld);

    // R9
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trk_vld |=> ($stable(pt_val) && $stable(pt_addr)));

    // R4
    pair_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_vld && !$past(three_st)) |-> (pt_addr[D2_LO +: D2_W] == '0));

    // R5
    eta_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pt_vld |-> ((pt_addr[ETA_LO +: ETA_W] == $past(eta)) &&
                    (pt_addr[TYPE_LO +: TYPE_W] == $past(trk_type))));
endmodule

bind mom_addr_former maf_chk #(
    .ETA_W(ETA_W), .TYPE_W(TYPE_W), .D1_W(D1_W), .D2_W(D2_W),
    .PT_W(PT_W), .ADDR_W(ADDR_W)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .trk_vld (trk_vld),
    .three_st(three_st),
    .eta     (eta),
    .trk_type(trk_type),
    .pt_vld  (pt_vld),
    .pt_val  (pt_val),
    .pt_addr (pt_addr)
);

// File: tb/mom_addr_former_tb_top.sv
module mom_addr_former_tb_top;
    localparam int NV   = 9;
    localparam int DEPTH = 1024;

    // phi_a, phi_b, phi_c, eta, type, three_st
    localparam logic [44:0] VEC [NV] = '{
        {12'd1000, 12'd990,  12'd970,  4'd3,  4'd5,  1'b1},
        {12'd990,  12'd1000, 12'd1030, 4'd7,  4'd6,  1'b1},
        {12'd3000, 12'd100,  12'd50,   4'd1,  4'd2,  1'b1},
        {12'd100,  12'd3000, 12'd4000, 4'd15, 4'd15, 1'b1},
        {12'd500,  12'd373,  12'd0,    4'd2,  4'd9,  1'b0},
        {12'd372,  12'd500,  12'd4095, 4'd0,  4'd0,  1'b0},
        {12'd2000, 12'd2000, 12'd1930, 4'd9,  4'd3,  1'b1},
        {12'd2000, 12'd2001, 12'd2003, 4'd4,  4'd12, 1'b1},
        {12'd2500, 12'd2372, 12'd2436, 4'd10, 4'd1,  1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trk_vld = 1'b0;
    logic [11:0] phi_a = '0, phi_b = '0, phi_c = '0;
    logic        three_st = 1'b0;
    logic [3:0]  eta = '0, trk_type = '0;
    logic        wr_en = 1'b0;
    logic [20:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        pt_vld;
    logic [7:0]  pt_val;
    logic [20:0] pt_addr;

    int checks = 0;
    int failures = 0;
    logic [7:0] model [DEPTH];

    always #10 clk = ~clk;

    mom_addr_former dut_i (
        .clk(clk), .rst_n(rst_n), .trk_vld(trk_vld),
        .phi_a(phi_a), .phi_b(phi_b), .phi_c(phi_c), .three_st(three_st),
        .eta(eta), .trk_type(trk_type),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pt_vld(pt_vld), .pt_val(pt_val), .pt_addr(pt_addr)
    );

    function automatic int clamp(int v, int lo, int hi);
        return (v > hi) ? hi : ((v < lo) ? lo : v);
    endfunction

    // Expected address from the requirements R2..R5
    function automatic logic [20:0] exp_addr(logic [44:0] v);
        int a, b, c, d1, d2;
        a  = int'(v[44:33]);
        b  = int'(v[32:21]);
        c  = int'(v[20:9]);
        d1 = clamp(a - b, -128, 127);
        d2 = v[0] ? clamp((b - c) >>> 2, -16, 15) : 0;
        return {v[4:1], v[8:5], d2[4:0], d1[7:0]};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_entry(logic [20:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model[a[9:0]] = d;
    endtask

    task automatic apply_vec(logic [44:0] v);
        phi_a = v[44:33]; phi_b = v[32:21]; phi_c = v[20:9];
        eta = v[8:5]; trk_type = v[4:1]; three_st = v[0];
    endtask

    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [20:0] ea;
        logic [7:0]  old_v, held_v;
        logic [20:0] held_a;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 vld in reset", 32'(pt_vld), 0);
        check("R1 val in reset", 32'(pt_val), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 vld after reset", 32'(pt_vld), 0);
        check("R1 addr after reset", 32'(pt_addr), 0);

        // Fill table entries used by the vectors (R7: signed words)
        for (int i = 0; i < NV; i++)
            write_entry(exp_addr(VEC[i]), 8'(i * 29 - 100));

        // Vector loop: R2, R3, R4, R5, R6, R7
        for (int i = 0; i < NV; i++) begin
            ea = exp_addr(VEC[i]);
            @(negedge clk);
            apply_vec(VEC[i]); trk_vld = 1'b1;
            @(negedge clk);
            trk_vld = 1'b0;
            check("R6 vld", 32'(pt_vld), 1);
            check("R2 d1 field", 32'(pt_addr[7:0]), 32'(ea[7:0]));
            check(VEC[i][0] ? "R3 d2 field" : "R4 d2 zero",
                  32'(pt_addr[12:8]), 32'(ea[12:8]));
            check("R5 eta/type", 32'(pt_addr[20:13]), 32'(ea[20:13]));
            check("R7 pt value", 32'(pt_val), 32'(model[ea[9:0]]));
            @(negedge clk);
            check("R6 vld drops", 32'(pt_vld), 0);
        end

        // R8: same-entry write and read in one cycle
        ea = exp_addr(VEC[0]);
        old_v = model[ea[9:0]];
        @(negedge clk);
        apply_vec(VEC[0]); trk_vld = 1'b1;
        wr_en = 1'b1; wr_addr = ea; wr_data = 8'h81;
        @(negedge clk);
        trk_vld = 1'b0; wr_en = 1'b0;
        model[ea[9:0]] = 8'h81;
        check("R8 old value", 32'(pt_val), 32'(old_v));
        @(negedge clk);
        trk_vld = 1'b1;
        @(negedge clk);
        trk_vld = 1'b0;
        check("R8 new value", 32'(pt_val), 32'h81);

        // R9: idle cycles with changing inputs and writes
        held_v = pt_val;
        held_a = pt_addr;
        for (int k = 0; k < 3; k++) begin
            apply_vec(VEC[k + 2]);
            wr_en = 1'b1; wr_addr = ea; wr_data = 8'(k + 5);
            @(negedge clk);
            check("R9 vld idle", 32'(pt_vld), 0);
            check("R9 val held", 32'(pt_val), 32'(held_v));
            check("R9 addr held", 32'(pt_addr), 32'(held_a));
        end
        wr_en = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule